// File: doc/BRIEF.md
# Buffer Event Interrupt Controller

This block collects buffer-related hardware conditions (receive DMA finished, ready to accept a transmit frame, transmit underrun and the other buffer events) into a 16-bit event register. It also keeps a 16-bit interrupt-enable register that the host can write. A single registered interrupt line is raised whenever a pending event has its enable set. Software can also raise an interrupt directly. It does this by writing a one to a request bit in the configuration register. The request bit acts once and never stays set.

The host reaches both registers through a small port. `sel_i` picks the register: 0 selects configuration and 1 selects events. The port also has separate read and write strobes. Each register returns a fixed 6-bit identifier in bits 5:0. Bit 6 belongs to the software interrupt. Bits 15:7 hold the nine hardware events, with `hw_evt_i[k]` mapped to bit 7+k. The mapping is receive-DMA-done on k=0, ready-for-transmit on k=1 and transmit underrun on k=2. Reading the event register returns the pending flags and clears them in the same cycle.

Top module: `bufevt_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, every enable is 0 and no event flag is pending.
- R2: Bits 5:0 of the configuration register always read 6'b001011, and bits 5:0 of the event register always read 6'b001100. Writes do not change either identifier.
- R3: A write to the configuration register (sel_i=0) stores data bits 15:7 as the enables for event bits 15:7, and a read returns them in those positions.
- R4: A one-cycle pulse on `hw_evt_i[k]` sets event bit 7+k at the next clock edge. Receive-DMA-done sets bit 7, ready-for-transmit sets bit 8 and transmit underrun sets bit 9.
- R5: Writing configuration data with bit 6 = 1 sets event bit 6 at the next edge, and that flag interrupts without any enable. Configuration bit 6 always reads 0. No further software flag appears until bit 6 is written as 1 again.
- R6: `irq_o` is registered and equals the OR of event bits 15:7 ANDed with their enables, ORed with event bit 6. It reflects a state change at the same edge that makes the change.
- R7: An event whose enable is 0 still sets its flag but does not raise `irq_o`. Setting the enable later raises `irq_o` at the edge of that write.
- R8: A read of the event register (sel_i=1, rd_en_i=1) returns the current flags and clears them at the next edge. An event arriving in the cycle of the read is kept and shows up on the following read.
- R9: Writes to the event register change neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select: 0 configuration, 1 events |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; on the event register it clears the flags |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, combinational while rd_en_i is high, otherwise 0 |
| hw_evt_i | input | 9 | Hardware event pulses, bit k sets event bit 7+k |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that read and write strobes do not arrive in the same cycle. They also assume each event pulse lasts one clock and is synchronous to `clk`. The bench honours both assumptions. Every host access is driven on the falling edge and held for exactly one cycle, and event pulses are issued the same way. The one overlap the bench creates on purpose is an event pulse during an event-register read, which is the retention case of R8.

// File: rtl/bufevt_pkg.sv
package bufevt_pkg;
    localparam int DATA_W = 16;
    localparam int ID_W   = 6;
    localparam int SW_BIT = ID_W;
    localparam int HW_N   = DATA_W - ID_W - 1;
    localparam logic [ID_W-1:0] CFG_ID = 6'b001011;
    localparam logic [ID_W-1:0] EVT_ID = 6'b001100;

    typedef enum logic {
        SEL_CFG = 1'b0,
        SEL_EVT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/bufevt_enable_reg.sv
module bufevt_enable_reg #(
    parameter int DATA_W = 16,
    parameter int SW_BIT = 6,
    localparam int HW_N = DATA_W - SW_BIT - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wr_data,
    output logic [HW_N-1:0]   en_q_o,
    output logic [HW_N-1:0]   en_d_o,
    output logic              sw_req_o
);
    typedef struct packed {
        logic [HW_N-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.en = wr_data[DATA_W-1:SW_BIT+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // act-once request: decoded from the write, never stored
    assign sw_req_o = wr_cfg & wr_data[SW_BIT];
    assign en_q_o   = st_q.en;
    assign en_d_o   = st_d.en;

    a_r3_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> en_q_o == $past(wr_data[DATA_W-1:SW_BIT+1]));
endmodule

// File: rtl/bufevt_flag_reg.sv
module bufevt_flag_reg #(
    parameter int HW_N = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW_N-1:0] hw_evt,
    input  logic          sw_set,
    input  logic          clr,
    output logic [HW_N:0] flags_q_o,
    output logic [HW_N:0] flags_d_o
);
    typedef struct packed {
        logic [HW_N:0] flags;  // bit 0 software, bits HW_N:1 hardware
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flags = '0;
        end
        st_d.flags = st_d.flags | {hw_evt, sw_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q_o = st_q.flags;
    assign flags_d_o = st_d.flags;

    a_r4_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((flags_q_o[HW_N:1] & $past(hw_evt)) == $past(hw_evt)));

    a_r5_sw_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> flags_q_o[0]);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|hw_evt) && !sw_set) |=> flags_q_o == '0);
endmodule

// File: rtl/bufevt_irq_ctrl.sv
module bufevt_irq_ctrl
    import bufevt_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int HN = DW - ID_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    input  logic [HN-1:0] hw_evt_i,
    output logic          irq_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    logic [HN-1:0] en_q, en_d;
    logic [HN:0]   flags_q, flags_d;
    logic          sw_req, wr_cfg, rd_evt;

    assign wr_cfg = wr_en_i && (reg_sel_e'(sel_i) == SEL_CFG);
    assign rd_evt = rd_en_i && (reg_sel_e'(sel_i) == SEL_EVT);

    bufevt_enable_reg #(.DATA_W(DW), .SW_BIT(SW_BIT)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .wr_data  (wr_data_i),
        .en_q_o   (en_q),
        .en_d_o   (en_d),
        .sw_req_o (sw_req)
    );

    bufevt_flag_reg #(.HW_N(HN)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt    (hw_evt_i),
        .sw_set    (sw_req),
        .clr       (rd_evt),
        .flags_q_o (flags_q),
        .flags_d_o (flags_d)
    );

    always_comb begin
        st_d.irq = |({en_d, 1'b1} & flags_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (reg_sel_e'(sel_i) == SEL_EVT) rd_data_o = {flags_q, EVT_ID};
            else                              rd_data_o = {en_q, 1'b0, CFG_ID};
        end
    end

    a_r6_irq_follows_state: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |({en_q, 1'b1} & flags_q));

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q[HN:1] & en_q) == '0 && !flags_q[0]) |-> !irq_o);
endmodule

// File: tb/bufevt_irq_ctrl_tb.sv
module bufevt_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic [8:0]  hw_evt_i = '0;
    logic        irq_o;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    bufevt_irq_ctrl u_dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [15:0] d);
        @(negedge clk); sel_i = s; wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
        #1;
    endtask

    task automatic rd(input logic s, output logic [15:0] d, input logic [8:0] evt = '0);
        @(negedge clk); sel_i = s; rd_en_i = 1'b1; hw_evt_i = evt;
        #1 d = rd_data_o;
        @(negedge clk); rd_en_i = 1'b0; hw_evt_i = '0;
        #1;
    endtask

    task automatic pulse(input logic [8:0] evt);
        @(negedge clk); hw_evt_i = evt;
        @(negedge clk); hw_evt_i = '0;
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq after reset", {15'd0, irq_o}, 16'h0000);
        rd(1'b0, v); check("R1/R2 config reset", v, 16'h000B);
        rd(1'b1, v); check("R1/R2 event reset", v, 16'h000C);
    endtask

    task automatic t_config();
        logic [15:0] v;
        wr(1'b0, 16'hFFBF);
        rd(1'b0, v); check("R3/R2 config readback", v, 16'hFF8B);
        check("R6 no irq without flags", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_events();
        logic [15:0] v;
        pulse(9'b000000001);
        check("R6 irq on rx dma", {15'd0, irq_o}, 16'h0001);
        rd(1'b1, v); check("R4 rx dma bit7", v, 16'h008C);
        check("R8 irq drops after read", {15'd0, irq_o}, 16'h0000);
        rd(1'b1, v); check("R8 flags cleared", v, 16'h000C);
        pulse(9'b000000100);
        rd(1'b1, v); check("R4 underrun bit9", v, 16'h020C);
        pulse(9'b000000010);
        rd(1'b1, v); check("R4 ready-tx bit8", v, 16'h010C);
    endtask

    task automatic t_masked();
        logic [15:0] v;
        wr(1'b0, 16'h0000);
        pulse(9'b000000100);
        check("R7 masked no irq", {15'd0, irq_o}, 16'h0000);
        wr(1'b0, 16'h0200);
        check("R7 irq on late enable", {15'd0, irq_o}, 16'h0001);
        rd(1'b1, v); check("R7 masked flag kept", v, 16'h020C);
    endtask

    task automatic t_sw();
        logic [15:0] v;
        wr(1'b0, 16'h0040);
        check("R5 sw irq", {15'd0, irq_o}, 16'h0001);
        rd(1'b0, v); check("R5 request bit reads 0", v, 16'h000B);
        rd(1'b1, v); check("R5 sw flag bit6", v, 16'h004C);
        repeat (3) @(negedge clk);
        #1 check("R5 act-once no repeat", {15'd0, irq_o}, 16'h0000);
        rd(1'b1, v); check("R5 no new sw flag", v, 16'h000C);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        wr(1'b0, 16'hFF80);
        pulse(9'b000000001);
        rd(1'b1, v, 9'b000001000); check("R8 read returns old flags", v, 16'h008C);
        check("R8 retained event irq", {15'd0, irq_o}, 16'h0001);
        rd(1'b1, v); check("R8 retained event bit10", v, 16'h040C);
    endtask

    task automatic t_evt_write();
        logic [15:0] v;
        pulse(9'b000000010);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); check("R9 event write no clear", v, 16'h010C);
        wr(1'b1, 16'hFFFF);
        check("R9 event write no irq", {15'd0, irq_o}, 16'h0000);
        rd(1'b1, v); check("R9 event write no set", v, 16'h000C);
        rd(1'b0, v); check("R9/R2 enables intact", v, 16'hFF8B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_config();
        t_events();
        t_masked();
        t_sw();
        t_same_cycle();
        t_evt_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule